// File: doc/BRIEF.md
# FIFO-Buffered Configuration Port Bridge

This peripheral connects a 32-bit memory-mapped register bus to a word-wide device configuration port. On the outbound side, software pushes words into a 1024-entry transmit queue and then sets a control bit. The block streams the queued words out over a valid/ready interface. It moves at most one word per clock, and a word leaves only on a cycle where both valid and ready are high. Software may set the start bit again while a transfer is running, to extend it with more words.

On the inbound side, software writes a word count into a length register and sets a second control bit. The block then accepts exactly that many words from the port into a 256-entry receive queue. Ready is only offered while the receive queue has room, so a full queue holds the port back until software drains it.

Software polls a done flag, a vacancy count and an occupancy count. Control bits empty both queues or return the whole block to its defaults. Four queue-level events feed a toggle-on-write interrupt status register. An enable mask and a global gate combine them into one interrupt line.

Top module: `cfgport_bridge`

## Requirements
- R1: After reset the status register (0x110) reads 0x1E plus the done flag (bit 0) set, with bits 8:5 reflecting the port status pins; vacancy (0x114) reads 1024, occupancy (0x118) reads 0 and `irq` is low.
- R2: A bus write to 0x100 appends bus_wdata to the transmit queue; writes while 1024 words are queued are dropped; vacancy always equals 1024 minus the words queued.
- R3: Writing 1 to control bit 0 (0x10C) streams the queued words out in push order, one per cycle on which `cfg_out_valid` and `cfg_out_ready` are both high; no word is lost or repeated while ready is held low.
- R4: Status bit 0 reads 0 while words are still draining or a readback is open, and returns to 1 once the transmit queue is empty or the readback count is reached; setting control bit 0 again during a drain extends it to the newly pushed words.
- R5: The length register (0x108, bits 11:0, maximum 0xFFF) bounds a readback started by control bit 1: exactly that many words are accepted, after which `cfg_in_ready` stays low; a length of 0 accepts nothing and leaves done at 1.
- R6: `cfg_in_ready` is low whenever the receive queue holds 256 words, and the queue never exceeds that.
- R7: A bus read of 0x104 returns the oldest received word and removes it; words come out in arrival order; a read of an empty queue leaves occupancy at 0.
- R8: Status bits 4:1 always read 1; bit 5 is the active-low abort pin, bit 6 the read-busy pin, bit 7 the aligned pin, bit 8 the error pin.
- R9: Writing 1 to control bit 2 empties both queues in that cycle: vacancy reads 1024 and occupancy 0 afterwards.
- R10: Writing 1 to control bit 3 empties both queues, stops any transfer and returns the length, interrupt status, interrupt enable and global enable registers to 0.
- R11: Interrupt status (0x20) bit 0 sets when the transmit queue reaches 512 words, bit 1 when the receive queue reaches 128, bit 2 when the transmit queue becomes empty and bit 3 when the receive queue reaches 256; writing 1 to a bit toggles it.
- R12: `irq` is high exactly when bit 31 of the global enable register (0x1C) is set and some interrupt status bit is set together with its bit in the enable register (0x28, same layout).
- R13: The control register reads back 0, as its bits act only on the cycle they are written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe; pops the receive queue at 0x104 |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cfg_out_valid | output | 1 | Outbound word available |
| cfg_out_ready | input | 1 | Port accepts the outbound word |
| cfg_out_data | output | 32 | Outbound word |
| cfg_in_valid | input | 1 | Port offers an inbound word |
| cfg_in_ready | output | 1 | Block accepts the inbound word |
| cfg_in_data | input | 32 | Inbound word |
| cfg_abort_n | input | 1 | Port abort indication, active low |
| cfg_rd_busy | input | 1 | Port read-in-progress indication |
| cfg_aligned | input | 1 | Port word-alignment indication |
| cfg_error | input | 1 | Port configuration error indication |
| irq | output | 1 | Interrupt request |

## Verification
Most internal faults show up at the bus within a few cycles. A queue pointer or count that slips shows as a wrong vacancy or occupancy on the next register read, or as a reordered or repeated word at the port. A readback counter that is off by one accepts one word too many or too few; this is visible on the handshake count as soon as the port stays valid after the expected end. A stuck engine flag holds the done bit low, which the first status read after the expected finish exposes. A wrong interrupt edge detector leaves a status bit set or clear that the register read and the `irq` pin show at once.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_GIE   = 12'h01C;
  localparam logic [ADDR_W-1:0] A_ISR   = 12'h020;
  localparam logic [ADDR_W-1:0] A_IER   = 12'h028;
  localparam logic [ADDR_W-1:0] A_TXQ   = 12'h100;
  localparam logic [ADDR_W-1:0] A_RXQ   = 12'h104;
  localparam logic [ADDR_W-1:0] A_LEN   = 12'h108;
  localparam logic [ADDR_W-1:0] A_CTRL  = 12'h10C;
  localparam logic [ADDR_W-1:0] A_STAT  = 12'h110;
  localparam logic [ADDR_W-1:0] A_VAC   = 12'h114;
  localparam logic [ADDR_W-1:0] A_OCC   = 12'h118;

  localparam int CTL_DRAIN = 0;
  localparam int CTL_FETCH = 1;
  localparam int CTL_FLUSH = 2;
  localparam int CTL_SRST  = 3;
  localparam int GIE_BIT   = 31;

  // interrupt vector, bit 0 is tx_half
  typedef struct packed {
    logic rx_full;
    logic tx_empty;
    logic rx_half;
    logic tx_half;
  } evt_t;

  localparam evt_t EVT_IDLE = '{rx_full: 1'b0, tx_empty: 1'b1,
                                rx_half: 1'b0, tx_half: 1'b0};

  typedef struct packed {
    logic error;
    logic aligned;
    logic rd_busy;
    logic abort_n;
  } pstat_t;
endpackage

// File: rtl/cfgb_fifo.sv
module cfgb_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R2 / R6: occupancy never passes the depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R2: a push into a full queue leaves it full and unchanged
  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/cfgb_engine.sv
module cfgb_engine #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             start_tx,
  input  logic             start_rx,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             tx_empty,
  input  logic             rx_full,
  input  logic             out_ready,
  input  logic             in_valid,
  output logic             out_valid,
  output logic             tx_pop,
  output logic             in_ready,
  output logic             rx_push,
  output logic             done
);
  logic             drain_q;
  logic             fetch_q;
  logic [LEN_W-1:0] left_q;

  assign out_valid = drain_q && !tx_empty;
  assign tx_pop    = out_valid && out_ready;
  assign in_ready  = fetch_q && !rx_full;
  assign rx_push   = in_ready && in_valid;
  assign done      = !drain_q && !fetch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q <= 1'b0;
    end else if (kill) begin
      drain_q <= 1'b0;
    end else if (start_tx && !fetch_q) begin
      drain_q <= 1'b1;
    end else if (drain_q && tx_empty) begin
      drain_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= 1'b0;
      left_q  <= '0;
    end else if (kill) begin
      fetch_q <= 1'b0;
      left_q  <= '0;
    end else if (start_rx && !fetch_q && !drain_q) begin
      fetch_q <= (rx_len != '0);
      left_q  <= rx_len;
    end else if (rx_push) begin
      left_q <= left_q - 1'b1;
      if (left_q == LEN_W'(1)) fetch_q <= 1'b0;
    end
  end

  // R5: no word is taken once the requested count is exhausted
  p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_q && rx_push && left_q == LEN_W'(1) && !kill) |=> !in_ready);
endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
  import cfgb_pkg::*;
#(
  parameter int TX_DEPTH = 1024,
  parameter int RX_DEPTH = 256,
  parameter int LEN_W    = 12,
  localparam int TX_CW = $clog2(TX_DEPTH) + 1,
  localparam int RX_CW = $clog2(RX_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        cfg_out_valid,
  input  logic        cfg_out_ready,
  output logic [31:0] cfg_out_data,
  input  logic        cfg_in_valid,
  output logic        cfg_in_ready,
  input  logic [31:0] cfg_in_data,
  input  logic        cfg_abort_n,
  input  logic        cfg_rd_busy,
  input  logic        cfg_aligned,
  input  logic        cfg_error,
  output logic        irq
);
  // register decode
  logic ctrl_wr, srst, flush, start_tx, start_rx;
  logic tx_wr, rx_rd;

  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign srst     = ctrl_wr && bus_wdata[CTL_SRST];
  assign flush    = (ctrl_wr && bus_wdata[CTL_FLUSH]) || srst;
  assign start_tx = ctrl_wr && bus_wdata[CTL_DRAIN] && !srst;
  assign start_rx = ctrl_wr && bus_wdata[CTL_FETCH] && !srst;
  assign tx_wr    = bus_wr && (bus_addr == A_TXQ);
  assign rx_rd    = bus_rd && (bus_addr == A_RXQ);

  // queues and engine
  logic [31:0]      tx_dout, rx_dout;
  logic [TX_CW-1:0] tx_count;
  logic [RX_CW-1:0] rx_count;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_pop, rx_push, done;
  logic [LEN_W-1:0] len_q;

  cfgb_fifo #(.WIDTH(32), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .push(tx_wr), .din(bus_wdata), .pop(tx_pop),
    .dout(tx_dout), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  cfgb_fifo #(.WIDTH(32), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .push(rx_push), .din(cfg_in_data), .pop(rx_rd),
    .dout(rx_dout), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  cfgb_engine #(.LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .kill(srst),
    .start_tx(start_tx), .start_rx(start_rx), .rx_len(len_q),
    .tx_empty(tx_empty), .rx_full(rx_full),
    .out_ready(cfg_out_ready), .in_valid(cfg_in_valid),
    .out_valid(cfg_out_valid), .tx_pop(tx_pop),
    .in_ready(cfg_in_ready), .rx_push(rx_push), .done(done)
  );

  assign cfg_out_data = tx_dout;

  // software registers
  logic gie_q;
  evt_t ier_q, isr_q, lvl_q, lvl;

  assign lvl.tx_half  = (tx_count >= TX_CW'(TX_DEPTH / 2));
  assign lvl.rx_half  = (rx_count >= RX_CW'(RX_DEPTH / 2));
  assign lvl.tx_empty = tx_empty;
  assign lvl.rx_full  = rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      ier_q <= '0;
      isr_q <= '0;
      lvl_q <= EVT_IDLE;
      len_q <= '0;
    end else if (srst) begin
      gie_q <= 1'b0;
      ier_q <= '0;
      isr_q <= '0;
      lvl_q <= EVT_IDLE;
      len_q <= '0;
    end else begin
      lvl_q <= lvl;
      isr_q <= (isr_q ^ ((bus_wr && bus_addr == A_ISR) ? evt_t'(bus_wdata[3:0]) : '0))
             | (lvl & ~lvl_q);
      if (bus_wr && bus_addr == A_GIE) gie_q <= bus_wdata[GIE_BIT];
      if (bus_wr && bus_addr == A_IER) ier_q <= evt_t'(bus_wdata[3:0]);
      if (bus_wr && bus_addr == A_LEN) len_q <= bus_wdata[LEN_W-1:0];
    end
  end

  assign irq = gie_q && |(isr_q & ier_q);

  // read mux
  pstat_t           pst;
  logic [8:0]       stat_word;
  logic [TX_CW-1:0] tx_vac;

  assign pst       = '{error: cfg_error, aligned: cfg_aligned,
                       rd_busy: cfg_rd_busy, abort_n: cfg_abort_n};
  assign stat_word = {pst, 4'b1111, done};
  assign tx_vac    = TX_CW'(TX_DEPTH) - tx_count;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_GIE:  bus_rdata[GIE_BIT] = gie_q;
      A_ISR:  bus_rdata[3:0] = isr_q;
      A_IER:  bus_rdata[3:0] = ier_q;
      A_RXQ:  bus_rdata = rx_dout;
      A_LEN:  bus_rdata[LEN_W-1:0] = len_q;
      A_STAT: bus_rdata[8:0] = stat_word;
      A_VAC:  bus_rdata[TX_CW-1:0] = tx_vac;
      A_OCC:  bus_rdata[RX_CW-1:0] = rx_count;
      default: bus_rdata = '0;
    endcase
  end

  // R6: ready is never offered into a full receive queue
  p_ready_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_in_ready |-> (rx_count < RX_CW'(RX_DEPTH)));
  // R4: a word on the port means done is low
  p_busy_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_out_valid |-> !stat_word[0]);
  // R9: a clear leaves both queues empty on the next cycle
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[CTL_FLUSH]) |=> (tx_empty && rx_empty));
  // R7: a pop with nothing stored keeps occupancy at zero
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty && !rx_push) |=> (rx_count == '0));
endmodule

// File: tb/cfgport_bridge_bench.sv
`timescale 1ns/1ps
module cfgport_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cfg_out_valid, cfg_in_ready;
  logic        cfg_out_ready = 1'b0;
  logic [31:0] cfg_out_data;
  logic        cfg_in_valid = 1'b0;
  logic [31:0] cfg_in_data = '0;
  logic        cfg_abort_n = 1'b1, cfg_rd_busy = 1'b0, cfg_aligned = 1'b0, cfg_error = 1'b0;
  logic        irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  cfgport_bridge u_cfgport_bridge (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_out_valid(cfg_out_valid), .cfg_out_ready(cfg_out_ready),
    .cfg_out_data(cfg_out_data), .cfg_in_valid(cfg_in_valid),
    .cfg_in_ready(cfg_in_ready), .cfg_in_data(cfg_in_data),
    .cfg_abort_n(cfg_abort_n), .cfg_rd_busy(cfg_rd_busy),
    .cfg_aligned(cfg_aligned), .cfg_error(cfg_error), .irq(irq)
  );

  always #4 clk = ~clk;

  localparam logic [11:0] GIE = 12'h01C, ISR = 12'h020, IER = 12'h028,
    TXQ = 12'h100, RXQ = 12'h104, LEN = 12'h108, CTRL = 12'h10C,
    STAT = 12'h110, VAC = 12'h114, OCC = 12'h118;

  // outbound sink log
  logic [31:0] rx_log [2048];
  int          rx_n = 0;
  initial forever begin
    @(negedge clk); #3;
    if (cfg_out_valid && cfg_out_ready && rx_n < 2048) begin
      rx_log[rx_n] = cfg_out_data;
      rx_n++;
    end
  end

  // inbound source: data = A000_0000 + words accepted so far
  bit src_en = 0, pend = 0;
  int src_cnt = 0;
  initial forever begin
    @(negedge clk); #2;
    if (pend) src_cnt++;
    cfg_in_data  = 32'hA000_0000 + src_cnt;
    cfg_in_valid = src_en;
    #1 pend = cfg_in_valid && cfg_in_ready;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(STAT, v); chk(v == 32'h3F, "R1 status", v, 32'h3F);
    rd(VAC, v);  chk(v == 32'd1024, "R1 vacancy", v, 32'd1024);
    rd(OCC, v);  chk(v == 32'd0, "R1 occupancy", v, 32'd0);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);
    rd(CTRL, v); chk(v == 32'd0, "R13 ctrl", v, 32'd0);
  endtask

  task automatic t_drain();
    logic [31:0] v;
    int n0 = rx_n;
    cfg_out_ready = 1'b1;
    for (int i = 0; i < 5; i++) wr(TXQ, 32'h1000_0000 + i);
    rd(VAC, v); chk(v == 32'd1019, "R2 vacancy", v, 32'd1019);
    wr(CTRL, 32'h1);
    rd(STAT, v); chk(v[0] == 1'b0, "R4 busy", v, 32'h0);
    rd(CTRL, v); chk(v == 32'd0, "R13 ctrl after start", v, 32'd0);
    idle(20);
    rd(STAT, v); chk(v[0] == 1'b1, "R4 done", v, 32'h1);
    chk(rx_n - n0 == 5, "R3 count", 32'(rx_n - n0), 32'd5);
    for (int i = 0; i < 5; i++)
      chk(rx_log[n0+i] == 32'h1000_0000 + i, "R3 order", rx_log[n0+i], 32'h1000_0000 + i);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    int n0 = rx_n;
    cfg_out_ready = 1'b0;
    for (int i = 0; i < 3; i++) wr(TXQ, 32'h2000_0000 + i);
    wr(CTRL, 32'h1);
    idle(10);
    chk(rx_n == n0, "R3 stalled", 32'(rx_n - n0), 32'd0);
    rd(STAT, v); chk(v[0] == 1'b0, "R4 busy while stalled", v, 32'h0);
    for (int i = 3; i < 5; i++) wr(TXQ, 32'h2000_0000 + i);
    wr(CTRL, 32'h1);
    cfg_out_ready = 1'b1;
    idle(20);
    chk(rx_n - n0 == 5, "R4 extended count", 32'(rx_n - n0), 32'd5);
    for (int i = 0; i < 5; i++)
      chk(rx_log[n0+i] == 32'h2000_0000 + i, "R3 stalled order", rx_log[n0+i], 32'h2000_0000 + i);
    rd(STAT, v); chk(v[0] == 1'b1, "R4 done after extend", v, 32'h1);
  endtask

  task automatic t_full();
    logic [31:0] v;
    int n0 = rx_n;
    cfg_out_ready = 1'b0;
    for (int i = 0; i < 1030; i++) wr(TXQ, 32'h5000_0000 + i);
    rd(VAC, v); chk(v == 32'd0, "R2 full vacancy", v, 32'd0);
    wr(CTRL, 32'h1);
    cfg_out_ready = 1'b1;
    idle(1100);
    chk(rx_n - n0 == 1024, "R2 dropped extras", 32'(rx_n - n0), 32'd1024);
    chk(rx_log[n0+1023] == 32'h5000_03FF, "R2 last word", rx_log[n0+1023], 32'h5000_03FF);
    rd(VAC, v); chk(v == 32'd1024, "R2 vacancy restored", v, 32'd1024);
  endtask

  task automatic t_status();
    logic [31:0] v;
    cfg_error = 1'b1; cfg_aligned = 1'b1; cfg_rd_busy = 1'b0; cfg_abort_n = 1'b0;
    rd(STAT, v); chk(v == 32'h19F, "R8 pins a", v, 32'h19F);
    cfg_error = 1'b0; cfg_aligned = 1'b0; cfg_rd_busy = 1'b1; cfg_abort_n = 1'b1;
    rd(STAT, v); chk(v == 32'h07F, "R8 pins b", v, 32'h07F);
    cfg_rd_busy = 1'b0;
  endtask

  task automatic t_readback();
    logic [31:0] v;
    int base;
    src_en = 1;
    idle(3);
    base = src_cnt;
    wr(LEN, 32'd10);
    rd(LEN, v); chk(v == 32'd10, "R5 length reg", v, 32'd10);
    wr(CTRL, 32'h2);
    idle(30);
    chk(src_cnt - base == 10, "R5 exact count", 32'(src_cnt - base), 32'd10);
    chk(cfg_in_ready == 1'b0, "R5 ready low after", 32'(cfg_in_ready), 32'd0);
    rd(STAT, v); chk(v[0] == 1'b1, "R4 readback done", v, 32'h1);
    rd(OCC, v); chk(v == 32'd10, "R7 occupancy", v, 32'd10);
    for (int i = 0; i < 10; i++) begin
      rd(RXQ, v);
      chk(v == 32'hA000_0000 + base + i, "R7 order", v, 32'hA000_0000 + base + i);
    end
    rd(RXQ, v);
    rd(OCC, v); chk(v == 32'd0, "R7 empty read", v, 32'd0);
  endtask

  task automatic t_len0();
    logic [31:0] v;
    int base = src_cnt;
    wr(LEN, 32'd0);
    wr(CTRL, 32'h2);
    rd(STAT, v); chk(v[0] == 1'b1, "R5 zero length done", v, 32'h1);
    idle(10);
    chk(src_cnt == base, "R5 zero length accepts none", 32'(src_cnt - base), 32'd0);
  endtask

  task automatic t_backpressure();
    logic [31:0] v;
    int base;
    rd(ISR, v); wr(ISR, v);
    rd(ISR, v); chk(v == 32'd0, "R11 toggle clear", v, 32'd0);
    base = src_cnt;
    wr(LEN, 32'd300);
    wr(CTRL, 32'h2);
    idle(300);
    rd(OCC, v); chk(v == 32'd256, "R6 occupancy cap", v, 32'd256);
    chk(cfg_in_ready == 1'b0, "R6 ready low when full", 32'(cfg_in_ready), 32'd0);
    chk(src_cnt - base == 256, "R6 accepted", 32'(src_cnt - base), 32'd256);
    rd(STAT, v); chk(v[0] == 1'b0, "R4 busy during readback", v, 32'h0);
    rd(ISR, v); chk(v == 32'hA, "R11 rx half and full", v, 32'hA);
    for (int i = 0; i < 100; i++) begin
      rd(RXQ, v);
      if (v != 32'hA000_0000 + base + i)
        chk(1'b0, "R7 order under pressure", v, 32'hA000_0000 + base + i);
    end
    idle(100);
    rd(OCC, v); chk(v == 32'd200, "R5 remaining words", v, 32'd200);
    rd(STAT, v); chk(v[0] == 1'b1, "R5 done after length", v, 32'h1);
    for (int i = 100; i < 300; i++) begin
      rd(RXQ, v);
      if (v != 32'hA000_0000 + base + i)
        chk(1'b0, "R7 order tail", v, 32'hA000_0000 + base + i);
    end
    chk(src_cnt - base == 300, "R5 total", 32'(src_cnt - base), 32'd300);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(IER, 32'h8);
    chk(irq == 1'b0, "R12 gated off", 32'(irq), 32'd0);
    wr(GIE, 32'h8000_0000);
    chk(irq == 1'b1, "R12 asserted", 32'(irq), 32'd1);
    wr(ISR, 32'h8);
    rd(ISR, v); chk(v == 32'h2, "R11 toggle bit3", v, 32'h2);
    chk(irq == 1'b0, "R12 masked source", 32'(irq), 32'd0);
    wr(IER, 32'h2);
    chk(irq == 1'b1, "R12 other source", 32'(irq), 32'd1);
    wr(ISR, 32'h2);
    chk(irq == 1'b0, "R11 toggle bit1", 32'(irq), 32'd0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    cfg_out_ready = 1'b0;
    for (int i = 0; i < 4; i++) wr(TXQ, 32'h3000_0000 + i);
    wr(LEN, 32'd3);
    wr(CTRL, 32'h2);
    idle(10);
    rd(OCC, v); chk(v == 32'd3, "R9 pre occupancy", v, 32'd3);
    wr(CTRL, 32'h4);
    rd(VAC, v); chk(v == 32'd1024, "R9 vacancy", v, 32'd1024);
    rd(OCC, v); chk(v == 32'd0, "R9 occupancy", v, 32'd0);
    rd(ISR, v); chk(v[2] == 1'b1, "R11 tx empty event", v, 32'h4);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    src_en = 0;
    wr(IER, 32'hF);
    chk(irq == 1'b1, "R12 before reset", 32'(irq), 32'd1);
    for (int i = 0; i < 3; i++) wr(TXQ, 32'h4000_0000 + i);
    wr(LEN, 32'd5);
    wr(CTRL, 32'h8);
    rd(LEN, v); chk(v == 32'd0, "R10 length", v, 32'd0);
    rd(IER, v); chk(v == 32'd0, "R10 enable", v, 32'd0);
    rd(GIE, v); chk(v == 32'd0, "R10 global", v, 32'd0);
    rd(ISR, v); chk(v == 32'd0, "R10 status", v, 32'd0);
    rd(VAC, v); chk(v == 32'd1024, "R10 vacancy", v, 32'd1024);
    rd(STAT, v); chk(v == 32'h3F, "R10 done", v, 32'h3F);
    chk(irq == 1'b0, "R10 irq", 32'(irq), 32'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_drain();
    t_stall();
    t_full();
    t_status();
    t_readback();
    t_len0();
    t_backpressure();
    t_irq();
    t_clear();
    t_srst();
    summary();
  end
endmodule